// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a two-stage pipelined arithmetic unit for 32-bit words that hold packed small integers. In four-lane mode it treats each operand word as four bytes. It multiplies byte i of `op_a` by byte i of `op_b` for every lane and adds the four products to the 32-bit accumulator input `op_c`. In two-lane mode it treats `op_a` as two 16-bit halves and multiplies each half by one byte chosen from `op_b`. The byte pair comes from the upper or the lower half of `op_b`, as the half-select input directs. The two products are then added to `op_c`.

Each multiplicand word has its own signedness control, so signed-by-unsigned mixes are handled directly. All arithmetic wraps modulo 2^32. The unit saturates nothing and raises no flags. A new operation can be accepted every cycle, and its result leaves with a fixed latency of two cycles.

Top module: `packed_dot_acc`

## Requirements
- R1: With `op_pair`=0, `result` = `op_c` + Σ(i=0..3) A_i·B_i, where A_i = `op_a`[8i+7:8i] and B_i = `op_b`[8i+7:8i]; byte i is always paired with byte i.
- R2: `a_signed`=1 sign-extends every lane taken from `op_a` (bytes or halves); `a_signed`=0 zero-extends them; this is independent of `b_signed`.
- R3: `b_signed`=1 sign-extends every byte taken from `op_b`; `b_signed`=0 zero-extends it; this is independent of `a_signed`.
- R4: With `op_pair`=1, `result` = `op_c` + `op_a`[15:0]·Blo + `op_a`[31:16]·Bhi, where Blo and Bhi are the lower and the upper of the two chosen bytes of `op_b`.
- R5: In two-lane mode, `hi_sel`=1 chooses Blo=`op_b`[23:16] and Bhi=`op_b`[31:24]; `hi_sel`=0 chooses Blo=`op_b`[7:0] and Bhi=`op_b`[15:8].
- R6: In four-lane mode `hi_sel` has no effect on `result`.
- R7: Every product and sum wraps modulo 2^32; accumulating past 0x7FFFFFFF or 0xFFFFFFFF wraps without saturation.
- R8: `out_valid` is high in exactly the cycles that follow, by two clock edges, a cycle with `in_valid` high. The operation accepted in that cycle is presented on `result`. Back-to-back inputs are accepted every cycle.
- R9: A synchronous active-low `rst_n` clears both pipeline valid bits. `out_valid` is low in the cycle after any cycle with `rst_n` low, and an operation presented while `rst_n` is low never produces an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First multiplicand word (four bytes or two halves) |
| op_b | input | 32 | Second multiplicand word (four bytes) |
| op_c | input | 32 | Accumulator addend |
| op_pair | input | 1 | 0: four-lane byte mode, 1: two-lane halfword mode |
| hi_sel | input | 1 | Two-lane mode: 1 takes the upper byte pair of op_b, 0 the lower |
| a_signed | input | 1 | 1: sign-extend lanes of op_a, 0: zero-extend |
| b_signed | input | 1 | 1: sign-extend bytes of op_b, 0: zero-extend |
| out_valid | output | 1 | result is valid this cycle |
| result | output | 32 | Dot product plus op_c, modulo 2^32 |

## Verification
The sweep crosses all sixteen settings of mode, half select and the two signedness bits with bytes of 0x80 and 0xFF, halves of 0x8000, and accumulators near 0x7FFFFFFF and 0xFFFFFFFF. The effects of bad extension and bad lane pairing therefore show up as sign errors. A unit that zero-extends where it should sign-extend, or the reverse, is off by a multiple of 256 or 65536 in exactly those vectors. A unit that mixes up the byte pair or the lane pairing gives results that differ between the two half selects, or no difference where there should be one. A mishandled accumulator carry shows up on the vectors whose sums cross 2^31 or 2^32. Idle cycles between operations and a reset pulse in the middle of a stream test the valid timing. A design that gives the wrong latency, leaks a valid bit through reset, or emits a result for an input that arrived during reset is caught there.

// File: rtl/pdot_pkg.sv
// Shared constants and types for the packed dot-product accumulator.
// Assumes four byte lanes per word; two-lane mode uses the lower two lanes.
package pdot_pkg;
    localparam int NLANES     = 4;
    localparam int PAIR_LANES = 2;

    typedef enum logic {
        OP_QUAD = 1'b0,
        OP_PAIR = 1'b1
    } dot_op_e;
endpackage

// File: rtl/pdot_lane_mult.sv
// One lane multiplier: widens an AW-bit and a BW-bit operand by one bit,
// sign or zero per its own control, and forms their exact signed product.
// Assumes PW >= AW + BW + 2 so that no product bit is lost.
module pdot_lane_mult #(
    parameter int AW = 16,
    parameter int BW = 8,
    parameter int PW = AW + BW + 2
) (
    input  logic [AW-1:0]        a_raw,
    input  logic                 a_sgn,
    input  logic [BW-1:0]        b_raw,
    input  logic                 b_sgn,
    output logic signed [PW-1:0] prod
);
    logic signed [AW:0] a_x;
    logic signed [BW:0] b_x;

    // Extend each operand by one bit chosen by its signedness control.
    always_comb begin
        a_x  = $signed({a_sgn & a_raw[AW-1], a_raw});
        b_x  = $signed({b_sgn & b_raw[BW-1], b_raw});
        prod = a_x * b_x;
    end
endmodule

// File: rtl/pdot_product_stage.sv
// First pipeline stage: steers byte or halfword lanes to the lane
// multipliers and registers the lane products, the addend and valid.
// Lanes below PAIR_LANES have wide multipliers shared by both modes; the
// rest are byte-only and are forced to zero in two-lane mode.
module pdot_product_stage
    import pdot_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int WORD_W = NLANES * LANE_W,
    localparam int HALF_W = 2 * LANE_W,
    localparam int PROD_W = HALF_W + LANE_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [WORD_W-1:0]              a,
    input  logic [WORD_W-1:0]              b,
    input  logic [WORD_W-1:0]              c,
    input  dot_op_e                        op,
    input  logic                           hi_sel,
    input  logic                           a_sgn,
    input  logic                           b_sgn,
    output logic                           s1_valid,
    output logic [NLANES-1:0][PROD_W-1:0]  s1_prod,
    output logic [WORD_W-1:0]              s1_c
);
    logic [NLANES-1:0][PROD_W-1:0] lane_prod;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        logic [LANE_W-1:0] a_byte;
        logic [LANE_W-1:0] b_byte;
        assign a_byte = a[i*LANE_W +: LANE_W];
        assign b_byte = b[i*LANE_W +: LANE_W];

        if (i < PAIR_LANES) begin : g_wide
            logic [HALF_W-1:0]        a_sel;
            logic [LANE_W-1:0]        b_sel;
            logic [LANE_W-1:0]        b_hi_byte;
            logic signed [PROD_W-1:0] wide_prod;
            assign b_hi_byte = b[(i + PAIR_LANES)*LANE_W +: LANE_W];

            // Pick a halfword and a chosen byte in pair mode, else this byte lane.
            always_comb begin
                if (op == OP_PAIR) begin
                    a_sel = a[i*HALF_W +: HALF_W];
                    b_sel = hi_sel ? b_hi_byte : b_byte;
                end else begin
                    a_sel = {{LANE_W{a_sgn & a_byte[LANE_W-1]}}, a_byte};
                    b_sel = b_byte;
                end
            end

            pdot_lane_mult #(.AW(HALF_W), .BW(LANE_W), .PW(PROD_W)) u_mult (
                .a_raw(a_sel), .a_sgn(a_sgn),
                .b_raw(b_sel), .b_sgn(b_sgn),
                .prod (wide_prod)
            );
            assign lane_prod[i] = wide_prod;
        end else begin : g_narrow
            localparam int NPW = 2 * LANE_W + 2;
            logic signed [NPW-1:0] narrow_prod;

            pdot_lane_mult #(.AW(LANE_W), .BW(LANE_W), .PW(NPW)) u_mult (
                .a_raw(a_byte), .a_sgn(a_sgn),
                .b_raw(b_byte), .b_sgn(b_sgn),
                .prod (narrow_prod)
            );
            assign lane_prod[i] = (op == OP_PAIR) ? '0 : PROD_W'(narrow_prod);
        end
    end

    // Valid bit of stage one, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Data of stage one, free-running and not reset.
    always_ff @(posedge clk) begin
        s1_prod <= lane_prod;
        s1_c    <= c;
    end
endmodule

// File: rtl/pdot_sum_stage.sv
// Second pipeline stage: sign-extends the registered lane products,
// adds them to the addend modulo 2^WORD_W and registers the result.
// Assumes PROD_W <= WORD_W.
module pdot_sum_stage
    import pdot_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PROD_W = 26
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           s1_valid,
    input  logic [NLANES-1:0][PROD_W-1:0]  s1_prod,
    input  logic [WORD_W-1:0]              s1_c,
    output logic                           out_valid,
    output logic [WORD_W-1:0]              result
);
    logic [WORD_W-1:0] total;

    // Wrapping sum of the addend and all lane products.
    always_comb begin
        total = s1_c;
        for (int i = 0; i < NLANES; i++) begin
            total = total + WORD_W'($signed(s1_prod[i]));
        end
    end

    // Output valid bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    // Output data register, not reset.
    always_ff @(posedge clk) begin
        result <= total;
    end
endmodule

// File: rtl/packed_dot_acc.sv
// Packed integer dot-product accumulator, two pipeline stages.
// Four-lane byte mode or two-lane halfword-by-byte mode, per-operand
// signedness, wrapping 32-bit result two cycles after a valid input.
// Assumes a synchronous active-low reset; data registers are not reset.
module packed_dot_acc
    import pdot_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int WORD_W = NLANES * LANE_W,
    localparam int PROD_W = 3 * LANE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] op_c,
    input  logic              op_pair,
    input  logic              hi_sel,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    logic                          s1_valid;
    logic [NLANES-1:0][PROD_W-1:0] s1_prod;
    logic [WORD_W-1:0]             s1_c;
    dot_op_e                       op_mode;

    assign op_mode = op_pair ? OP_PAIR : OP_QUAD;

    pdot_product_stage #(.LANE_W(LANE_W)) u_prod (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .a       (op_a),
        .b       (op_b),
        .c       (op_c),
        .op      (op_mode),
        .hi_sel  (hi_sel),
        .a_sgn   (a_signed),
        .b_sgn   (b_signed),
        .s1_valid(s1_valid),
        .s1_prod (s1_prod),
        .s1_c    (s1_c)
    );

    pdot_sum_stage #(.WORD_W(WORD_W), .PROD_W(PROD_W)) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_prod  (s1_prod),
        .s1_c     (s1_c),
        .out_valid(out_valid),
        .result   (result)
    );
endmodule

// File: rtl/pdot_acc_checker.sv
// Protocol and arithmetic properties of packed_dot_acc, observed at its ports.
module pdot_acc_checker #(
    parameter int LANE_W = 8,
    localparam int WORD_W = 4 * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic [WORD_W-1:0] op_c,
    input logic              op_pair,
    input logic              hi_sel,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);                                        // R8
    AST_NO_PHANTOM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));                                  // R8
    AST_RESET_DRAINS: assert property (@(posedge clk)
        !rst_n |=> !out_valid);                                             // R9
    AST_QUAD_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && !op_pair && op_a == '0, 2))
            |-> result == $past(op_c, 2));                                  // R1
    AST_PAIR_LOW_ZERO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && op_pair && !hi_sel
                            && op_b[2*LANE_W-1:0] == '0, 2))
            |-> result == $past(op_c, 2));                                  // R5
    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(result));                                 // R8
endmodule

bind packed_dot_acc pdot_acc_checker #(.LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .op_c     (op_c),
    .op_pair  (op_pair),
    .hi_sel   (hi_sel),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/packed_dot_acc_bench.sv
`timescale 1ns/1ps
module packed_dot_acc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        op_pair = 1'b0, hi_sel = 1'b0, a_signed = 1'b0, b_signed = 1'b0;
    logic        out_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        pv_v [2] = '{1'b0, 1'b0};
    logic [31:0] pv_e [2] = '{32'h0, 32'h0};
    string       pv_t [2] = '{"R9", "R9"};

    always #2.5 clk = ~clk;

    packed_dot_acc u_packed_dot_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .op_pair(op_pair), .hi_sel(hi_sel),
        .a_signed(a_signed), .b_signed(b_signed),
        .out_valid(out_valid), .result(result)
    );

    function automatic longint ext8(input logic [7:0] v, input logic s);
        return s ? longint'($signed(v)) : longint'(v);
    endfunction

    function automatic longint ext16(input logic [15:0] v, input logic s);
        return s ? longint'($signed(v)) : longint'(v);
    endfunction

    // Arithmetic reference from R1..R7.
    function automatic logic [31:0] ref_dot(input logic [31:0] a, b, c,
                                            input logic op, hi, as, bs);
        longint acc = longint'(c);
        if (!op) begin
            for (int i = 0; i < 4; i++)
                acc += ext8(a[8*i +: 8], as) * ext8(b[8*i +: 8], bs);
        end else begin
            for (int i = 0; i < 2; i++)
                acc += ext16(a[16*i +: 16], as) * ext8(b[(hi ? 16 : 0) + 8*i +: 8], bs);
        end
        return acc[31:0];
    endfunction

    function automatic string tag_for(input logic op, as, bs);
        string t = op ? "R4 R5" : "R1 R6";
        if (as) t = {t, " R2"};
        if (bs) t = {t, " R3"};
        return {t, " R7"};
    endfunction

    function automatic logic [31:0] a_val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h8080_8080;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_7FFF;
            4: return 32'h7F01_FF80;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [31:0] b_val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h8080_8080;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7F80_FF01;
            default: return 32'hA5C3_3C5A;
        endcase
    endfunction

    function automatic logic [31:0] c_val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h7FFF_FFFF;
            default: return 32'hFFFF_FFF0;
        endcase
    endfunction

    // Compare the outputs with the entry issued two cycles earlier.
    task automatic check_out();
        n_checks++;
        if (out_valid !== pv_v[1]) begin
            n_fail++;
            $display("FAIL %s (R8 valid timing): out_valid=%b expected=%b",
                     pv_t[1], out_valid, pv_v[1]);
        end else if (pv_v[1]) begin
            n_checks++;
            if (result !== pv_e[1]) begin
                n_fail++;
                $display("FAIL %s: result=%h expected=%h", pv_t[1], result, pv_e[1]);
            end
        end
    endtask

    // One cycle: check the output, then drive the next input set.
    task automatic step(input logic v, input logic [31:0] a, b, c,
                        input logic op, hi, as, bs, input logic rst_lo);
        @(negedge clk);
        check_out();
        pv_v[1] = pv_v[0]; pv_e[1] = pv_e[0]; pv_t[1] = pv_t[0];
        in_valid = v; op_a = a; op_b = b; op_c = c;
        op_pair = op; hi_sel = hi; a_signed = as; b_signed = bs;
        rst_n = !rst_lo;
        if (rst_lo) begin
            pv_v[0] = 1'b0; pv_v[1] = 1'b0;
            pv_t[0] = "R9"; pv_t[1] = "R9";
        end else begin
            pv_v[0] = v;
            pv_e[0] = ref_dot(a, b, c, op, hi, as, bs);
            pv_t[0] = v ? tag_for(op, hi, as) : "R8";
            if (v) pv_t[0] = tag_for(op, as, bs);
        end
    endtask

    initial begin
        int k = 0;
        // Reset state: valid low while reset is held (R9).
        for (int i = 0; i < 4; i++) step(1'b0, '0, '0, '0, 0, 0, 0, 0, 1'b1);
        // Full sweep of mode, half select and signedness over corner values.
        for (int m = 0; m < 16; m++) begin
            for (int ia = 0; ia < 6; ia++)
                for (int ib = 0; ib < 5; ib++)
                    for (int ic = 0; ic < 3; ic++) begin
                        step(1'b1, a_val(ia), b_val(ib), c_val(ic),
                             m[3], m[2], m[1], m[0], 1'b0);
                        k++;
                        if (k % 7 == 0) step(1'b0, '0, '0, '0, 0, 0, 0, 0, 1'b0);
                    end
        end
        for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, 0, 0, 0, 0, 1'b0);
        // Reset in mid-stream with valid inputs held high (R9).
        step(1'b1, 32'h0102_0304, 32'h0506_0708, 32'h10, 0, 0, 1, 1, 1'b0);
        step(1'b1, 32'h7FFF_8000, 32'hFF80_7F01, 32'h20, 1, 1, 1, 0, 1'b0);
        step(1'b1, 32'h1111_1111, 32'h2222_2222, 32'h30, 0, 0, 0, 0, 1'b1);
        step(1'b1, 32'h3333_3333, 32'h4444_4444, 32'h40, 0, 0, 0, 0, 1'b1);
        step(1'b1, 32'hFFFF_FFFF, 32'h8080_8080, 32'h7FFF_FFFF, 1, 0, 1, 1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, '0, '0, '0, 0, 0, 0, 0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (R8): run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule